// File: doc/BRIEF.md
# UART Line Status Unit

This block builds the eight-bit line status value of a UART and holds the receive queue that the status describes. The receiver reports each finished character with its data byte and three tags: bad parity, missing stop bit, and break. The block stores the tags next to the byte, so that the parity, framing and break flags always describe the character the CPU will read next. When the queue is full, a new character raises a sticky overrun flag and is thrown away. The queue contents stay as they were.

On the transmit side, the block watches the occupancy of the transmit queue, CPU writes into that queue, and a busy signal from the transmit shift register. From these it derives the holding-empty and transmitter-empty flags. A break on the line is queued once. Further break characters are discarded until the receive line has been seen high again.

Top module: `line_status_unit`

## Requirements
- R1: After a synchronous reset, `lsr_o` reads 0x60 (bits 5 and 6 set, all others clear) and the receive queue is empty.
- R2: Bit 0 of `lsr_o` is 1 exactly when the receive queue holds at least one character.
- R3: Accepted characters leave the queue in arrival order, with the oldest byte on `rx_head_o`. A pulse on `rx_rd_i` pops one entry at the next edge. A read while the queue is empty has no effect.
- R4: Bit 2 of `lsr_o` shows the parity tag of the head entry. It is 0 when the queue is empty.
- R5: Bit 3 of `lsr_o` shows the stop-bit tag of the head entry. It is 0 when the queue is empty.
- R6: Bit 4 of `lsr_o` shows the break tag of the head entry. It is 0 when the queue is empty.
- R7: A character that arrives with `rx_brk_i` set is queued only if break capture is armed, and queuing it disarms capture. Capture re-arms once `rx_line_i` is sampled high. A disarmed break character is neither stored nor counted as overrun.
- R8: If an accepted character arrives while the queue holds DEPTH entries, bit 1 of `lsr_o` sets at the next edge. The character is dropped and the queued entries stay unchanged. This holds even when a read occurs in the same cycle.
- R9: Bit 1 of `lsr_o` stays set until a cycle with `lsr_rd_i` high, and clears at the next edge. A new overrun in that same cycle keeps it set.
- R10: Bit 5 of `lsr_o` becomes, at each edge, 1 when `tx_level_i` was zero and `tx_wr_i` was low in that cycle. Otherwise it becomes 0.
- R11: Bit 6 of `lsr_o` follows the same rule as bit 5, and additionally needs `tsr_busy_i` low.
- R12: Bit 7 of `lsr_o` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_done_i | input | 1 | One-cycle pulse: the receiver finished a character |
| rx_data_i | input | 8 | Received byte, valid with rx_done_i |
| rx_par_bad_i | input | 1 | Parity check failed for this character |
| rx_stop_bad_i | input | 1 | Stop bit was missing for this character |
| rx_brk_i | input | 1 | This character is a break (line low for a whole frame) |
| rx_line_i | input | 1 | Current receive line level, used to re-arm break capture |
| rx_rd_i | input | 1 | CPU read of the receive queue head |
| lsr_rd_i | input | 1 | CPU read of the line status value |
| tx_wr_i | input | 1 | CPU write into the transmit queue |
| tx_level_i | input | CW | Transmit queue occupancy |
| tsr_busy_i | input | 1 | Transmit shift register holds a character |
| rx_head_o | output | 8 | Byte at the head of the receive queue |
| rx_level_o | output | CW | Receive queue occupancy |
| lsr_o | output | 8 | Line status value |

## Verification
A corrupted read pointer or a shifted tag field shows up on the very next status read. The error bits then describe the wrong character, and `rx_head_o` breaks the arrival order the bench tracks. A faulty full test, or a push that slips past it, is caught after the queue is drained: an extra byte appears where the dropped one should be missing. A wrong break arm state is exposed within one character, because a second break either appears in the queue or fails to appear. Stale transmit flags are visible one edge after the write or level change that should have moved them.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic b7;
        logic temt;
        logic thre;
        logic brk;
        logic frm;
        logic par;
        logic ovr;
        logic dr;
    } lsr_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    function automatic lsr_t build_lsr(input logic dr, input logic ovr,
                                       input rx_entry_t head,
                                       input logic thre, input logic temt);
        lsr_t r;
        r.dr   = dr;
        r.ovr  = ovr;
        r.par  = dr & head.par;
        r.frm  = dr & head.frm;
        r.brk  = dr & head.brk;
        r.thre = thre;
        r.temt = temt;
        r.b7   = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
    import lsr_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      push_i,
    input  rx_entry_t wdata_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic [CW-1:0] count_o,
    output logic      full_o
);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            do_push, do_pop;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign full_o  = (count == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && (count != '0);

    always_ff @(posedge clk_i) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign count_o = count;

endmodule

// File: rtl/lsr_rx_admit.sv
module lsr_rx_admit (
    input  logic clk_i,
    input  logic rst_i,
    input  logic done_i,
    input  logic brk_i,
    input  logic line_i,
    input  logic full_i,
    input  logic lsr_rd_i,
    output logic push_o,
    output logic ovr_o
);

    logic armed_q, ovr_q, accept;

    // a break character counts only while capture is armed
    assign accept = done_i && (!brk_i || armed_q);
    assign push_o = accept && !full_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            armed_q <= 1'b1;
            ovr_q   <= 1'b0;
        end else begin
            if (done_i && brk_i && armed_q) armed_q <= 1'b0;
            else if (line_i)                armed_q <= 1'b1;

            if (accept && full_i) ovr_q <= 1'b1;
            else if (lsr_rd_i)    ovr_q <= 1'b0;
        end
    end

    assign ovr_o = ovr_q;

endmodule

// File: rtl/lsr_tx_flags.sv
module lsr_tx_flags #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          wr_i,
    input  logic [CW-1:0] level_i,
    input  logic          busy_i,
    output logic          thre_o,
    output logic          temt_o
);

    logic q_empty;
    assign q_empty = (level_i == '0) && !wr_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            thre_o <= 1'b1;
            temt_o <= 1'b1;
        end else begin
            thre_o <= q_empty;
            temt_o <= q_empty && !busy_i;
        end
    end

endmodule

// File: rtl/line_status_unit.sv
module line_status_unit
    import lsr_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          rx_done_i,
    input  logic [7:0]    rx_data_i,
    input  logic          rx_par_bad_i,
    input  logic          rx_stop_bad_i,
    input  logic          rx_brk_i,
    input  logic          rx_line_i,
    input  logic          rx_rd_i,
    input  logic          lsr_rd_i,
    input  logic          tx_wr_i,
    input  logic [CW-1:0] tx_level_i,
    input  logic          tsr_busy_i,
    output logic [7:0]    rx_head_o,
    output logic [CW-1:0] rx_level_o,
    output logic [7:0]    lsr_o
);

    rx_entry_t wentry, head;
    logic      push, full, ovr, thre, temt, dr;
    lsr_t      status;

    assign wentry = '{brk: rx_brk_i, frm: rx_stop_bad_i,
                      par: rx_par_bad_i, data: rx_data_i};

    lsr_rx_admit admit_i (
        .clk_i(clk_i), .rst_i(rst_i), .done_i(rx_done_i), .brk_i(rx_brk_i),
        .line_i(rx_line_i), .full_i(full), .lsr_rd_i(lsr_rd_i),
        .push_o(push), .ovr_o(ovr)
    );

    lsr_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk_i(clk_i), .rst_i(rst_i), .push_i(push), .wdata_i(wentry),
        .pop_i(rx_rd_i), .head_o(head), .count_o(rx_level_o), .full_o(full)
    );

    lsr_tx_flags #(.CW(CW)) tx_i (
        .clk_i(clk_i), .rst_i(rst_i), .wr_i(tx_wr_i), .level_i(tx_level_i),
        .busy_i(tsr_busy_i), .thre_o(thre), .temt_o(temt)
    );

    assign dr        = (rx_level_o != '0);
    assign status    = build_lsr(dr, ovr, head, thre, temt);
    assign lsr_o     = status;
    assign rx_head_o = head.data;

endmodule

// File: rtl/line_status_chk.sv
module line_status_chk #(
    parameter int DEPTH = 128,
    parameter int CW = 8
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          rx_done_i,
    input logic          rx_brk_i,
    input logic          rx_rd_i,
    input logic          lsr_rd_i,
    input logic          tx_wr_i,
    input logic [CW-1:0] rx_level_o,
    input logic [7:0]    lsr_o
);

    // R8
    ovr_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_level_o == CW'(DEPTH) && rx_done_i && !rx_brk_i) |=> lsr_o[1]);

    // R8
    full_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_level_o == CW'(DEPTH) && !rx_rd_i) |=> rx_level_o == CW'(DEPTH));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lsr_o[1] && !lsr_rd_i) |=> lsr_o[1]);

    // R10
    thre_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_wr_i |=> !lsr_o[5]);

    // R11
    temt_sub_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !lsr_o[5] |-> !lsr_o[6]);

    // R3
    empty_rd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_level_o == '0 && !rx_done_i) |=> rx_level_o == '0);

    // R12
    bit7_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !lsr_o[7]);

endmodule

bind line_status_unit line_status_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .rx_done_i(rx_done_i), .rx_brk_i(rx_brk_i),
    .rx_rd_i(rx_rd_i), .lsr_rd_i(lsr_rd_i), .tx_wr_i(tx_wr_i),
    .rx_level_o(rx_level_o), .lsr_o(lsr_o)
);

// File: tb/line_status_unit_tb_top.sv
module line_status_unit_tb_top;

    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int N = 15;

    // ctrl bits: done par frm brk line rd_rbr rd_lsr tx_wr busy tx_has
    localparam logic [33:0] VEC [N] = '{
        {10'b1000100000, 8'hA5, 8'h61, 8'hA5},
        {10'b1100100000, 8'h3C, 8'h61, 8'hA5},
        {10'b0000110000, 8'h00, 8'h65, 8'h3C},
        {10'b1010100000, 8'h77, 8'h65, 8'h3C},
        {10'b0000110000, 8'h00, 8'h69, 8'h77},
        {10'b0000100100, 8'h00, 8'h09, 8'h77},
        {10'b0000100011, 8'h00, 8'h09, 8'h77},
        {10'b0000100010, 8'h00, 8'h29, 8'h77},
        {10'b0000100000, 8'h00, 8'h69, 8'h77},
        {10'b1011000000, 8'h00, 8'h69, 8'h77},
        {10'b1011010000, 8'h00, 8'h79, 8'h00},
        {10'b0000010000, 8'h00, 8'h60, 8'h00},
        {10'b0000100000, 8'h00, 8'h60, 8'h00},
        {10'b1001000000, 8'h00, 8'h71, 8'h00},
        {10'b0000110000, 8'h00, 8'h60, 8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_done = 0, rx_par = 0, rx_frm = 0, rx_brk = 0, rx_line = 1;
    logic rx_rd = 0, lsr_rd = 0, tx_wr = 0, tsr_busy = 0;
    logic [7:0] rx_data = '0;
    logic [CW-1:0] tx_level = '0;
    logic [7:0] rx_head, lsr;
    logic [CW-1:0] rx_level;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    line_status_unit #(.DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_i(rst), .rx_done_i(rx_done), .rx_data_i(rx_data),
        .rx_par_bad_i(rx_par), .rx_stop_bad_i(rx_frm), .rx_brk_i(rx_brk),
        .rx_line_i(rx_line), .rx_rd_i(rx_rd), .lsr_rd_i(lsr_rd),
        .tx_wr_i(tx_wr), .tx_level_i(tx_level), .tsr_busy_i(tsr_busy),
        .rx_head_o(rx_head), .rx_level_o(rx_level), .lsr_o(lsr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [9:0] c, input logic [7:0] d);
        @(negedge clk);
        {rx_done, rx_par, rx_frm, rx_brk, rx_line, rx_rd, lsr_rd, tx_wr, tsr_busy} = c[9:1];
        tx_level = c[0] ? CW'(3) : '0;
        rx_data = d;
        @(negedge clk);
        {rx_done, rx_par, rx_frm, rx_brk, rx_rd, lsr_rd, tx_wr} = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset lsr", lsr, 8'h60);
        check("R1 reset level", 8'(rx_level), 8'h00);

        // table of patterns
        for (int i = 0; i < N; i++) begin
            step(VEC[i][33:24], VEC[i][23:16]);
            check("R2/R4/R5/R6/R7/R10/R11 table lsr", lsr, VEC[i][15:8]);
            check("R12 bit7", {7'b0, lsr[7]}, 8'h00);
            if (VEC[i][8]) check("R3 table head", rx_head, VEC[i][7:0]);
        end

        // R3: read from empty queue is ignored
        step(10'b0000110000, 8'h00);
        check("R3 empty read level", 8'(rx_level), 8'h00);
        step(10'b1000100000, 8'h5A);
        check("R3 head after empty read", rx_head, 8'h5A);
        check("R2 one entry", lsr, 8'h61);
        step(10'b0000110000, 8'h00);

        // R8: fill, then overflow
        for (int k = 0; k < DEPTH; k++) step(10'b1000100000, 8'(k + 8'h10));
        check("R8 full level", 8'(rx_level), 8'(DEPTH));
        check("R8 no overrun yet", lsr, 8'h61);
        step(10'b1000100000, 8'hEE);
        check("R8 overrun set", lsr, 8'h63);
        check("R8 level unchanged", 8'(rx_level), 8'(DEPTH));
        // R9: new overrun in the clearing cycle keeps the flag
        step(10'b1000101000, 8'hEF);
        check("R9 set wins over clear", lsr, 8'h63);
        step(10'b0000101000, 8'h00);
        check("R9 cleared by status read", lsr, 8'h61);
        // R8: read and overrun in the same cycle, still dropped
        step(10'b1000110000, 8'hDD);
        check("R8 overrun with read", lsr, 8'h63);
        check("R8 level after read", 8'(rx_level), 8'(DEPTH - 1));
        check("R3 head after read", rx_head, 8'h11);
        for (int k = 1; k < DEPTH; k++) begin
            check("R8 intact order", rx_head, 8'(k + 8'h10));
            step(10'b0000110000, 8'h00);
        end
        check("R8 drained", 8'(rx_level), 8'h00);
        check("R9 sticky through reads", {7'b0, lsr[1]}, 8'h01);

        // R1: reset in mid-run
        step(10'b1100100100, 8'h42);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 mid-run reset lsr", lsr, 8'h60);
        check("R1 mid-run reset level", 8'(rx_level), 8'h00);

        finish_run();
    end

endmodule